// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

The router gathers five level-sensitive interrupt requests: two peripheral-interface chips (A and B), an Ethernet controller, a serial controller and a non-maskable source. It folds them into one eight-bit pending vector, and from that vector it drives a three-bit CPU interrupt level and a matching autovector number. A mode input selects one of two routing tables. The table decides which pending bit each source drives. In classic mode the Ethernet request does not enter the pending vector at all. It drives a separate expansion-slot interrupt line instead.

A source does not set or clear a pending bit on its own. An update happens only when the source's synchronised level changes, and it writes that level into the bit chosen by the mode in force at that moment. Switching the mode therefore never moves bits that are already pending. A push-button NMI input produces a held NMI request that lasts a set number of clock cycles. Pressing the button again while the hold runs restarts the hold.

Top module: `irq_router`

## Requirements
- R1: With `mode_classic_i` high, the sources map as follows: A drives pending bit 0 (level 1), B drives bit 1 (level 2), serial drives bit 3 (level 4) and NMI drives bit 6 (level 7).
- R2: With `mode_classic_i` low, the sources map as follows: A drives bit 5 (level 6), B drives bit 1 (level 2), Ethernet drives bit 2 (level 3), serial drives bit 3 (level 4) and NMI drives bit 6 (level 7).
- R3: In classic mode a change of the Ethernet request is written to `slot_irq_o` and leaves the pending vector untouched. In the other mode an Ethernet change leaves `slot_irq_o` unchanged.
- R4: `ipl_o` equals the index of the highest set pending bit plus one. `vec_o` equals that index plus 25. Both are 0 when no bit is pending. Pending bit 7 is never set.
- R5: Pending bits follow levels. A source rising sets its bit and a source falling clears it, with no edge latching.
- R6: When several bits are pending, the highest bit index sets the level.
- R7: A source update writes the bit chosen by the mode at the time of the update. A mode change does not move bits that are already pending, so a bit set under the old mode stays set until that same bit is written again.
- R8: A rising edge on `nmi_btn_i` holds the NMI source active for exactly `HOLD_CYCLES` cycles. A new press while the hold runs reloads the full count.
- R9: Reset clears the pending vector, the level, the vector, the slot output, the mode (to the non-classic table) and any running NMI hold.
- R10: Every input passes through a two-flop synchroniser. A request change is reflected in `slot_irq_o` on the third rising edge that samples it, and in `ipl_o`/`vec_o` on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_classic_i | input | 1 | Routing table select, 1 = classic |
| pia_a_irq_i | input | 1 | Peripheral-interface chip A request |
| pia_b_irq_i | input | 1 | Peripheral-interface chip B request |
| eth_irq_i | input | 1 | Ethernet controller request |
| ser_irq_i | input | 1 | Serial controller request |
| nmi_irq_i | input | 1 | Non-maskable request level |
| nmi_btn_i | input | 1 | NMI push button, stretched into a timed hold |
| ipl_o | output | 3 | CPU interrupt level |
| vec_o | output | 8 | Autovector number |
| slot_irq_o | output | 1 | Expansion-slot interrupt line |

## Verification
The bench builds the router with `HOLD_CYCLES` set to 20 in place of the 100 ms default. With that value a whole NMI hold fits in a short run, and so do its exact length, a restart in the middle of a hold and a reset during a hold. The synchroniser depth stays at its default. This keeps the reference model's three-edge and four-edge latencies equal to the ones stated in the requirements. It also brings within reach mode flips that happen while bits are pending, where bits end up stranded.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NSRC     = 5;
    localparam int PEND_W   = 8;
    localparam int IDX_W    = $clog2(PEND_W);
    localparam int IPL_W    = 3;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 25;

    localparam int SRC_PIA_A = 0;
    localparam int SRC_PIA_B = 1;
    localparam int SRC_ETH   = 2;
    localparam int SRC_SER   = 3;
    localparam int SRC_NMI   = 4;

    typedef struct packed {
        logic [NSRC-1:0]   last;
        logic [PEND_W-1:0] pend;
        logic              slot;
        logic [IPL_W-1:0]  ipl;
        logic [VEC_W-1:0]  vec;
    } route_state_t;

    // Pending bit chosen for a source under a given table.
    function automatic logic [IDX_W-1:0] route_bit(input logic classic, input int src);
        logic [IDX_W-1:0] b;
        b = '0;
        case (src)
            SRC_PIA_A: b = classic ? IDX_W'(0) : IDX_W'(5);
            SRC_PIA_B: b = IDX_W'(1);
            SRC_ETH:   b = IDX_W'(2);
            SRC_SER:   b = IDX_W'(3);
            SRC_NMI:   b = IDX_W'(6);
            default:   b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = async_i;
            end else begin : g_next
                assign stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/nmi_stretch.sv
module nmi_stretch #(
    parameter int HOLD_CYCLES = 5_000_000,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_i,
    output logic             hold_o,
    output logic             rise_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

    typedef struct packed {
        logic             btn_prev;
        logic [CNT_W-1:0] cnt;
    } stretch_t;

    stretch_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.btn_prev = btn_i;
        rise_o        = btn_i & ~st_q.btn_prev;
        if (rise_o) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = (st_q.cnt != '0);
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/prio_enc.sv
module prio_enc #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int HOLD_CYCLES = 5_000_000,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W  = $clog2(HOLD_CYCLES + 1),
    localparam int NSYNC  = NSRC + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_classic_i,
    input  logic             pia_a_irq_i,
    input  logic             pia_b_irq_i,
    input  logic             eth_irq_i,
    input  logic             ser_irq_i,
    input  logic             nmi_irq_i,
    input  logic             nmi_btn_i,
    output logic [IPL_W-1:0] ipl_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             slot_irq_o
);

    logic [NSYNC-1:0] raw_in, syn;
    logic             mode_s, btn_s, hold_act, btn_rise;
    logic [CNT_W-1:0] hold_cnt;
    logic [NSRC-1:0]  src;
    logic             enc_found;
    logic [IDX_W-1:0] enc_idx;

    route_state_t state_d, state_q;

    assign raw_in = {nmi_btn_i, mode_classic_i, nmi_irq_i, ser_irq_i,
                     eth_irq_i, pia_b_irq_i, pia_a_irq_i};

    irq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign mode_s = syn[NSRC];
    assign btn_s  = syn[NSRC+1];

    nmi_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn_i  (btn_s),
        .hold_o (hold_act),
        .rise_o (btn_rise),
        .cnt_o  (hold_cnt)
    );

    always_comb begin
        src          = syn[NSRC-1:0];
        src[SRC_NMI] = syn[SRC_NMI] | hold_act;
    end

    prio_enc #(.WIDTH(PEND_W)) u_enc (
        .req_i   (state_q.pend),
        .found_o (enc_found),
        .idx_o   (enc_idx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.last = src;
        for (int i = 0; i < NSRC; i++) begin
            if (src[i] != state_q.last[i]) begin
                if (mode_s && (i == SRC_ETH)) begin
                    state_d.slot = src[i];
                end else begin
                    state_d.pend[route_bit(mode_s, i)] = src[i];
                end
            end
        end
        if (enc_found) begin
            state_d.ipl = IPL_W'(32'(enc_idx) + 1);
            state_d.vec = VEC_W'(32'(enc_idx) + VEC_BASE);
        end else begin
            state_d.ipl = '0;
            state_d.vec = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ipl_o      = state_q.ipl;
    assign vec_o      = state_q.vec;
    assign slot_irq_o = state_q.slot;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int HOLD_CYCLES = 5_000_000,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IPL_W-1:0]  ipl,
    input logic [VEC_W-1:0]  vec,
    input logic              slot,
    input logic [PEND_W-1:0] pend,
    input logic              mode_s,
    input logic              btn_rise,
    input logic [CNT_W-1:0]  cnt
);

    p_vec_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl == '0) ? (vec == '0) : (32'(vec) == 32'(ipl) + VEC_BASE - 1));

    p_bit7_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[PEND_W-1]);

    p_enc_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pend) |=> $stable(ipl));

    p_slot_classic_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot) |-> $past(mode_s));

    p_hold_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rise |=> (32'(cnt) == HOLD_CYCLES));

    p_hold_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= HOLD_CYCLES);

endmodule

bind irq_router irq_router_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ipl      (ipl_o),
    .vec      (vec_o),
    .slot     (slot_irq_o),
    .pend     (state_q.pend),
    .mode_s   (mode_s),
    .btn_rise (btn_rise),
    .cnt      (hold_cnt)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;

    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0, pa = 1'b0, pb = 1'b0, eth = 1'b0, ser = 1'b0;
    logic       nmi = 1'b0, btn = 1'b0;
    logic [2:0] ipl_o;
    logic [7:0] vec_o;
    logic       slot_irq_o;

    int    checks = 0;
    int    errors = 0;
    string tag = "R9";
    bit    done = 0;

    always #5 clk = ~clk;

    irq_router #(.HOLD_CYCLES(HOLD)) u_irq_router (
        .clk(clk), .rst_n(rst_n), .mode_classic_i(mode),
        .pia_a_irq_i(pa), .pia_b_irq_i(pb), .eth_irq_i(eth),
        .ser_irq_i(ser), .nmi_irq_i(nmi), .nmi_btn_i(btn),
        .ipl_o(ipl_o), .vec_o(vec_o), .slot_irq_o(slot_irq_o)
    );

    // ---------------- behavioural reference model ----------------
    int   m_hist[$];        // sampled input words, newest at back
    int   m_prev_use;
    int   m_last[5];
    bit   m_pend[8];
    int   m_slot, m_ipl, m_vec, m_cnt;

    function automatic int pack_in();
        return {25'd0, btn, mode, nmi, ser, eth, pb, pa};
    endfunction

    function automatic int bit_of(int classic, int s);
        case (s)
            0: return classic ? 0 : 5;
            1: return 1;
            2: return 2;
            3: return 3;
            default: return 6;
        endcase
    endfunction

    task automatic model_reset();
        m_hist = {0, 0};
        m_prev_use = 0;
        foreach (m_last[i]) m_last[i] = 0;
        foreach (m_pend[i]) m_pend[i] = 0;
        m_slot = 0; m_ipl = 0; m_vec = 0; m_cnt = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int use_w, md, top;
            int src[5];
            use_w = m_hist[0];
            top = -1;
            for (int i = 0; i < 8; i++) if (m_pend[i]) top = i;
            m_ipl = (top < 0) ? 0 : top + 1;
            m_vec = (top < 0) ? 0 : top + 25;
            md = (use_w >> 5) & 1;
            for (int i = 0; i < 5; i++) src[i] = (use_w >> i) & 1;
            if (m_cnt != 0) src[4] = 1;
            for (int i = 0; i < 5; i++) begin
                if (src[i] != m_last[i]) begin
                    if (md == 1 && i == 2) m_slot = src[i];
                    else m_pend[bit_of(md, i)] = src[i][0];
                end
                m_last[i] = src[i];
            end
            if (((use_w >> 6) & 1) == 1 && ((m_prev_use >> 6) & 1) == 0) m_cnt = HOLD;
            else if (m_cnt > 0) m_cnt--;
            m_prev_use = use_w;
            void'(m_hist.pop_front());
            m_hist.push_back(pack_in());
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare against the model after every rising edge
    always begin
        @(posedge clk);
        #2;
        if (!done) begin
            check(tag, int'(ipl_o), m_ipl, "ipl");
            check(tag, int'(vec_o), m_vec, "vec");
            check(tag, int'(slot_irq_o), m_slot, "slot");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt7;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R9: reset state
        check("R9", int'(ipl_o), 0, "ipl after reset");
        check("R9", int'(vec_o), 0, "vec after reset");
        check("R9", int'(slot_irq_o), 0, "slot after reset");

        // R10: latency of a serial request in the default table
        tag = "R10";
        ser = 1'b1;
        repeat (3) @(posedge clk);
        #3 check("R10", int'(ipl_o), 0, "ipl before 4th edge");
        @(posedge clk);
        #3 check("R10", int'(ipl_o), 4, "ipl on 4th edge");
        cyc(2); ser = 1'b0; cyc(6);

        // R2 and R5: every source alone, default table
        tag = "R2";
        pa = 1; cyc(6); check("R2", int'(ipl_o), 6, "A alt"); pa = 0; cyc(6);
        tag = "R5"; check("R5", int'(ipl_o), 0, "A cleared");
        tag = "R2";
        pb = 1; cyc(6); check("R2", int'(ipl_o), 2, "B alt"); pb = 0; cyc(6);
        eth = 1; cyc(6); check("R2", int'(ipl_o), 3, "eth alt");
        check("R3", int'(slot_irq_o), 0, "slot untouched alt"); eth = 0; cyc(6);
        ser = 1; cyc(6); check("R2", int'(vec_o), 28, "ser alt vec"); ser = 0; cyc(6);
        nmi = 1; cyc(6); check("R2", int'(ipl_o), 7, "nmi alt"); nmi = 0; cyc(6);

        // R1 and R3: classic table
        tag = "R1";
        mode = 1; cyc(4);
        pa = 1; cyc(6); check("R1", int'(ipl_o), 1, "A classic");
        check("R4", int'(vec_o), 25, "vec A classic"); pa = 0; cyc(6);
        pb = 1; cyc(6); check("R1", int'(ipl_o), 2, "B classic"); pb = 0; cyc(6);
        ser = 1; cyc(6); check("R1", int'(ipl_o), 4, "ser classic"); ser = 0; cyc(6);
        nmi = 1; cyc(6); check("R1", int'(vec_o), 31, "nmi classic vec"); nmi = 0; cyc(6);
        tag = "R3";
        eth = 1; cyc(6);
        check("R3", int'(slot_irq_o), 1, "slot follows eth");
        check("R3", int'(ipl_o), 0, "eth bypasses pending");
        eth = 0; cyc(6);
        check("R3", int'(slot_irq_o), 0, "slot released");

        // R6: several pending at once, both tables
        tag = "R6";
        pa = 1; pb = 1; ser = 1; cyc(6); check("R6", int'(ipl_o), 4, "classic mix");
        nmi = 1; cyc(6); check("R6", int'(ipl_o), 7, "nmi wins");
        nmi = 0; ser = 0; cyc(6); check("R6", int'(ipl_o), 2, "B over A");
        pa = 0; pb = 0; cyc(6);
        mode = 0; cyc(4);
        pb = 1; eth = 1; cyc(6); check("R6", int'(ipl_o), 3, "eth over B alt");
        pa = 1; cyc(6); check("R6", int'(ipl_o), 6, "A over eth alt");
        pa = 0; pb = 0; eth = 0; cyc(6);

        // R7: mode change with bits pending
        tag = "R7";
        pa = 1; cyc(6);
        mode = 1; cyc(6); check("R7", int'(ipl_o), 6, "bit5 kept after flip");
        pa = 0; cyc(6); check("R7", int'(ipl_o), 6, "bit5 stranded");
        pa = 1; cyc(6);
        mode = 0; cyc(6);
        pa = 0; cyc(6); check("R7", int'(ipl_o), 1, "bit5 cleared, bit0 stranded");
        eth = 1; cyc(6); check("R7", int'(slot_irq_o), 0, "slot held alt");
        eth = 0; cyc(6);
        tag = "R9";
        do_reset(); cyc(1);
        check("R9", int'(ipl_o), 0, "stranded bit cleared by reset");

        // R8: NMI hold length and restart
        tag = "R8";
        cnt7 = 0;
        btn = 1; cyc(3); btn = 0;
        for (int k = 0; k < 3 * HOLD; k++) begin
            @(posedge clk); #3;
            if (ipl_o == 3'd7) cnt7++;
        end
        check("R8", cnt7, HOLD, "hold length");
        btn = 1; cyc(2); btn = 0; cyc(HOLD / 2);
        btn = 1; cyc(2); btn = 0; cyc(HOLD - 2);
        check("R8", int'(ipl_o), 7, "restarted hold still active");
        cyc(HOLD);
        check("R8", int'(ipl_o), 0, "restarted hold expired");

        // R9: reset cancels a running hold
        tag = "R9";
        btn = 1; cyc(2); btn = 0; cyc(8);
        do_reset(); cyc(HOLD + 5);
        check("R9", int'(ipl_o), 0, "hold cancelled by reset");

        cyc(4);
        finish_run();
    end

endmodule